// File: doc/BRIEF.md
# UART Power Management Controller

This block decides when the clocks of a UART's transmit and receive sections may be stopped. In automatic mode each section is watched on its own. The transmit clock is gated once the transmitter reports that it has nothing left to send. The receive clock is gated once the serial input has stayed free of transitions for five character times, counted in baud ticks. A host write to the transmit holding register wakes the transmitter. Any transition on the serial input wakes the receiver. Neither wake-up disturbs FIFO or register contents.

Direct mode is a software-commanded shutdown. It stops both section clocks at once and issues a single-cycle reset pulse to each FIFO. It ends when the command bit is cleared or when the module is reset. An idle flag tells software when the port holds no pending transmit data and has seen a quiet line for at least one character time, so that a direct shutdown will not drop traffic.

Top module: `uart_pm_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, both clock enables read 1, both FIFO reset pulses read 0 and `port_idle` reads 0 after that edge.
- R2: With `cfg_auto_en` at 0 and `cfg_direct_pd` at 0, both clock enables stay at 1 whatever the transmitter status, the host writes or the line activity.
- R3: With `cfg_auto_en` at 1, `tx_empty` at 1 and no transmit write pending, `tx_clk_en` reads 0 one clock after such a sample.
- R4: A sample of `thr_wr` at 1 drives `tx_clk_en` to 1 on the next clock (unless direct powerdown holds). The write stays pending, and keeps the transmitter awake, until `tx_empty` has been sampled at 0.
- R5: The receive quiet count advances only on clocks where `baud_tick` is 1. It saturates at CHAR_COUNT*FRAME_BITS*OVERSAMPLE ticks (800 by default). With `cfg_auto_en` at 1, `rx_clk_en` reads 0 on the clock after the saturated count is seen.
- R6: Any level change on `rx_in` passes through a two-flop synchroniser and an edge register. It clears the quiet count and sets `rx_clk_en` to 1 three clocks after the change.
- R7: A 0-to-1 change of `cfg_direct_pd` produces a pulse on both `tx_fifo_rst` and `rx_fifo_rst`. The pulse is exactly one clock long and starts one clock after the change is sampled.
- R8: While `cfg_direct_pd` is 1, both clock enables read 0 from the next clock on, overriding host writes and line activity. One clock after it is cleared, each enable follows its automatic state again, with no FIFO reset pulse.
- R9: `port_idle` reads 1 one clock after a sample where `tx_empty` is 1, `thr_wr` is 0, no write is pending and the quiet count is at least FRAME_BITS*OVERSAMPLE ticks. Otherwise it reads 0.
- R10: Entering or leaving automatic powerdown never pulses a FIFO reset.
- R11: A module reset ends direct powerdown: with `rst_n` low, both clock enables read 1 even while `cfg_direct_pd` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_auto_en | input | 1 | Enables automatic powerdown of both sections |
| cfg_direct_pd | input | 1 | Commands direct powerdown |
| tx_empty | input | 1 | Transmitter has nothing left to send |
| thr_wr | input | 1 | Host write strobe to the transmit holding register |
| rx_in | input | 1 | Asynchronous serial input line |
| baud_tick | input | 1 | One pulse per oversampling tick |
| tx_clk_en | output | 1 | Clock enable for the transmit section |
| rx_clk_en | output | 1 | Clock enable for the receive section |
| tx_fifo_rst | output | 1 | One-clock reset pulse for the transmit FIFO |
| rx_fifo_rst | output | 1 | One-clock reset pulse for the receive FIFO |
| port_idle | output | 1 | Port is safe to put into direct powerdown |

## Verification
The following results appear one clock after the input sample that causes them: the transmit enable, the FIFO reset pulses, the direct-mode gating and the idle flag. A receive wake-up appears three clocks after the line changes. Receive sleep comes only after the full saturated tick count. The bench drives inputs and compares every output at the falling clock edge against a cycle model that it advances at the rising edge. This puts each comparison after exactly the number of register stages the requirement names. The directed checks for the long receive window sample with a margin of several clocks on each side of the expected transition.

// File: rtl/uart_pm_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the UART power management controller.
// Assumes frame and oversampling figures are small positive integers.
package uart_pm_pkg;

    // Control bundle delivered to one UART section.
    typedef struct packed {
        logic clk_en;
        logic fifo_rst;
    } pm_sect_t;

    // Number of baud ticks in a given number of characters.
    function automatic int unsigned char_ticks(input int unsigned chars,
                                               input int unsigned bits,
                                               input int unsigned os);
        return chars * bits * os;
    endfunction

endpackage

// File: rtl/upm_rx_activity.sv
`timescale 1ns/1ps
// Receive activity monitor: synchronises the serial line, detects any
// transition, counts quiet baud ticks and requests receive sleep once the
// quiet window is complete. Assumes rx_async idles high and may change at
// any time relative to clk.
module upm_rx_activity #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned QUIET_TICKS = 800,
    parameter int unsigned CHAR_TICKS  = 160
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_async,
    input  logic baud_tick,
    input  logic auto_en,
    input  logic dpd_req,
    output logic rx_sleep,
    output logic char_quiet
);
    localparam int unsigned CNT_W = $clog2(QUIET_TICKS + 1);
    localparam logic [CNT_W-1:0] QUIET_MAX = CNT_W'(QUIET_TICKS);
    localparam logic [CNT_W-1:0] CHAR_MIN  = CNT_W'(CHAR_TICKS);

    logic [SYNC_STAGES:0] line_q;
    logic [CNT_W-1:0]     quiet_cnt;
    logic                 line_edge;
    logic                 quiet_done;

    assign line_edge  = line_q[SYNC_STAGES-1] ^ line_q[SYNC_STAGES];
    assign quiet_done = (quiet_cnt == QUIET_MAX);
    assign char_quiet = (quiet_cnt >= CHAR_MIN);

    // Synchroniser chain plus one history stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= '1;
        else        line_q <= {line_q[SYNC_STAGES-1:0], rx_async};
    end

    // Quiet counter: cleared by any edge, advanced by ticks, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                         quiet_cnt <= '0;
        else if (line_edge)                 quiet_cnt <= '0;
        else if (baud_tick && !quiet_done)  quiet_cnt <= quiet_cnt + 1'b1;
    end

    // Receive sleep request: quiet window complete and no new edge.
    always_ff @(posedge clk) begin
        if (!rst_n) rx_sleep <= 1'b0;
        else        rx_sleep <= auto_en && !dpd_req && quiet_done && !line_edge;
    end

    // R6
    rx_edge_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_edge |=> !rx_sleep);

    // R5
    rx_sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_sleep |-> (quiet_cnt == QUIET_MAX));

endmodule

// File: rtl/upm_tx_activity.sv
`timescale 1ns/1ps
// Transmit activity monitor: tracks host writes to the holding register and
// requests transmit sleep when the transmitter has nothing to send. Assumes
// tx_empty drops within a few clocks of a write once the clock is running.
module upm_tx_activity (
    input  logic clk,
    input  logic rst_n,
    input  logic auto_en,
    input  logic dpd_req,
    input  logic tx_empty,
    input  logic thr_wr,
    output logic tx_sleep,
    output logic tx_pending
);

    // Pending write: set by a host write, cleared once the transmitter is busy.
    always_ff @(posedge clk) begin
        if (!rst_n)         tx_pending <= 1'b0;
        else if (dpd_req)   tx_pending <= 1'b0;
        else if (thr_wr)    tx_pending <= 1'b1;
        else if (!tx_empty) tx_pending <= 1'b0;
    end

    // Transmit sleep request: enabled, empty, and no write in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) tx_sleep <= 1'b0;
        else        tx_sleep <= auto_en && !dpd_req && tx_empty && !thr_wr && !tx_pending;
    end

    // R4
    tx_write_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        thr_wr |=> !tx_sleep);

    // R3
    tx_sleep_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_sleep |-> $past(tx_empty));

endmodule

// File: rtl/upm_direct_ctl.sv
`timescale 1ns/1ps
// Direct powerdown control: registers the software command and emits a
// single-clock FIFO reset pulse when the command rises. Assumes the command
// bit is a register output in the same clock domain.
module upm_direct_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic dpd_req,
    output logic dpd_active,
    output logic fifo_rst_pulse
);

    // Registered command state; cleared by module reset.
    always_ff @(posedge clk) begin
        if (!rst_n) dpd_active <= 1'b0;
        else        dpd_active <= dpd_req;
    end

    // One-clock pulse on the rising command.
    always_ff @(posedge clk) begin
        if (!rst_n) fifo_rst_pulse <= 1'b0;
        else        fifo_rst_pulse <= dpd_req && !dpd_active;
    end

    // R7
    fifo_rst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rst_pulse |=> !fifo_rst_pulse);

    // R10
    fifo_rst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rst_pulse |-> $past(dpd_req));

endmodule

// File: rtl/uart_pm_ctrl.sv
`timescale 1ns/1ps
// UART power management controller top. Combines per-section automatic
// sleep requests with direct powerdown to form section clock enables, FIFO
// reset pulses and an idle status flag. Assumes all inputs except rx_in are
// synchronous to clk.
module uart_pm_ctrl
    import uart_pm_pkg::*;
#(
    parameter int unsigned CHAR_COUNT  = 5,
    parameter int unsigned FRAME_BITS  = 10,
    parameter int unsigned OVERSAMPLE  = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_auto_en,
    input  logic cfg_direct_pd,
    input  logic tx_empty,
    input  logic thr_wr,
    input  logic rx_in,
    input  logic baud_tick,
    output logic tx_clk_en,
    output logic rx_clk_en,
    output logic tx_fifo_rst,
    output logic rx_fifo_rst,
    output logic port_idle
);
    localparam int unsigned QUIET_TICKS = char_ticks(CHAR_COUNT, FRAME_BITS, OVERSAMPLE);
    localparam int unsigned CHAR_TICKS  = char_ticks(1, FRAME_BITS, OVERSAMPLE);

    logic     rx_sleep, char_quiet;
    logic     tx_sleep, tx_pending;
    logic     dpd_active, fifo_rst_pulse;
    logic     idle_q;
    pm_sect_t tx_sect, rx_sect;

    upm_rx_activity #(
        .SYNC_STAGES (SYNC_STAGES),
        .QUIET_TICKS (QUIET_TICKS),
        .CHAR_TICKS  (CHAR_TICKS)
    ) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_async   (rx_in),
        .baud_tick  (baud_tick),
        .auto_en    (cfg_auto_en),
        .dpd_req    (cfg_direct_pd),
        .rx_sleep   (rx_sleep),
        .char_quiet (char_quiet)
    );

    upm_tx_activity u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .auto_en    (cfg_auto_en),
        .dpd_req    (cfg_direct_pd),
        .tx_empty   (tx_empty),
        .thr_wr     (thr_wr),
        .tx_sleep   (tx_sleep),
        .tx_pending (tx_pending)
    );

    upm_direct_ctl u_dpd (
        .clk            (clk),
        .rst_n          (rst_n),
        .dpd_req        (cfg_direct_pd),
        .dpd_active     (dpd_active),
        .fifo_rst_pulse (fifo_rst_pulse)
    );

    // Idle flag: transmitter drained and line quiet for a character time.
    always_ff @(posedge clk) begin
        if (!rst_n) idle_q <= 1'b0;
        else        idle_q <= tx_empty && !thr_wr && !tx_pending && char_quiet;
    end

    // Section control bundles: direct powerdown overrides automatic sleep.
    always_comb begin
        tx_sect.clk_en   = !dpd_active && !tx_sleep;
        tx_sect.fifo_rst = fifo_rst_pulse;
        rx_sect.clk_en   = !dpd_active && !rx_sleep;
        rx_sect.fifo_rst = fifo_rst_pulse;
    end

    assign tx_clk_en   = tx_sect.clk_en;
    assign rx_clk_en   = rx_sect.clk_en;
    assign tx_fifo_rst = tx_sect.fifo_rst;
    assign rx_fifo_rst = rx_sect.fifo_rst;
    assign port_idle   = idle_q;

    // R8
    direct_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_direct_pd |=> (!tx_clk_en && !rx_clk_en));

    // R7
    direct_fifo_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_direct_pd && !dpd_active) |=> (tx_fifo_rst && rx_fifo_rst));

    // R9
    idle_tx_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        port_idle |-> $past(tx_empty && !thr_wr));

    // R2
    auto_off_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_auto_en && !cfg_direct_pd) |=> (tx_clk_en && rx_clk_en));

endmodule

// File: tb/uart_pm_ctrl_tb.sv
`timescale 1ns/1ps
module uart_pm_ctrl_tb;
    localparam int QT = 800;
    localparam int CT = 160;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_auto_en = 1'b0, cfg_direct_pd = 1'b1;
    logic tx_empty = 1'b1, thr_wr = 1'b0, rx_in = 1'b1, baud_tick = 1'b1;
    logic tx_clk_en, rx_clk_en, tx_fifo_rst, rx_fifo_rst, port_idle;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    uart_pm_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_auto_en(cfg_auto_en),
        .cfg_direct_pd(cfg_direct_pd), .tx_empty(tx_empty), .thr_wr(thr_wr),
        .rx_in(rx_in), .baud_tick(baud_tick), .tx_clk_en(tx_clk_en),
        .rx_clk_en(rx_clk_en), .tx_fifo_rst(tx_fifo_rst),
        .rx_fifo_rst(rx_fifo_rst), .port_idle(port_idle)
    );

    // Cycle model of the requirements, advanced at each rising edge.
    logic [2:0] m_line = 3'b111;
    int m_cnt = 0;
    logic m_rxs = 0, m_txs = 0, m_pend = 0, m_dpd = 0, m_pulse = 0, m_idle = 0;

    always @(posedge clk) begin : model
        bit e, qd;
        e  = m_line[1] ^ m_line[2];
        qd = (m_cnt == QT);
        if (!rst_n) begin
            m_line <= 3'b111; m_cnt <= 0; m_rxs <= 0; m_txs <= 0;
            m_pend <= 0; m_dpd <= 0; m_pulse <= 0; m_idle <= 0;
        end else begin
            m_line  <= {m_line[1:0], rx_in};
            m_cnt   <= e ? 0 : ((baud_tick && !qd) ? m_cnt + 1 : m_cnt);
            m_rxs   <= cfg_auto_en && !cfg_direct_pd && qd && !e;
            m_pend  <= cfg_direct_pd ? 1'b0 : (thr_wr ? 1'b1 : (!tx_empty ? 1'b0 : m_pend));
            m_txs   <= cfg_auto_en && !cfg_direct_pd && tx_empty && !thr_wr && !m_pend;
            m_dpd   <= cfg_direct_pd;
            m_pulse <= cfg_direct_pd && !m_dpd;
            m_idle  <= tx_empty && !thr_wr && !m_pend && (m_cnt >= CT);
        end
    end

    function automatic logic exp_tx_en();
        return !m_dpd && !m_txs;
    endfunction
    function automatic logic exp_rx_en();
        return !m_dpd && !m_rxs;
    endfunction

    task automatic chk(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare all outputs with the model; called at the falling edge.
    task automatic compare_all();
        chk("R3/R4 tx_clk_en model", tx_clk_en, exp_tx_en());
        chk("R5/R6 rx_clk_en model", rx_clk_en, exp_rx_en());
        chk("R7 tx_fifo_rst model", tx_fifo_rst, m_pulse);
        chk("R7 rx_fifo_rst model", rx_fifo_rst, m_pulse);
        chk("R9 port_idle model", port_idle, m_idle);
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare_all();
        end
    endtask

    initial begin : stim
        int seed;
        seed = $urandom(32'd4711);
        repeat (2) @(posedge clk);
        cyc(1);
        // R1 and R11: reset state while direct powerdown is requested
        chk("R11 tx_clk_en in reset", tx_clk_en, 1'b1);
        chk("R11 rx_clk_en in reset", rx_clk_en, 1'b1);
        chk("R1 tx_fifo_rst in reset", tx_fifo_rst, 1'b0);
        chk("R1 rx_fifo_rst in reset", rx_fifo_rst, 1'b0);
        chk("R1 port_idle in reset", port_idle, 1'b0);
        cfg_direct_pd = 1'b0; rst_n = 1'b1;

        // R2: auto disabled keeps both sections running
        cyc(900);
        chk("R2 tx_clk_en auto off", tx_clk_en, 1'b1);
        chk("R2 rx_clk_en auto off", rx_clk_en, 1'b1);

        // R3 / R5: enabling auto puts both sections to sleep
        cfg_auto_en = 1'b1;
        cyc(1);
        chk("R3 tx sleeps", tx_clk_en, 1'b0);
        chk("R5 rx sleeps", rx_clk_en, 1'b0);
        chk("R10 no fifo rst on auto sleep", tx_fifo_rst | rx_fifo_rst, 1'b0);

        // R6: line edge wakes the receiver after three clocks
        rx_in = 1'b0;
        cyc(2);
        chk("R6 rx still asleep before sync", rx_clk_en, 1'b0);
        cyc(1);
        chk("R6 rx awake", rx_clk_en, 1'b1);
        chk("R10 no fifo rst on wake", tx_fifo_rst | rx_fifo_rst, 1'b0);

        // R5: only baud ticks advance the quiet window
        rx_in = 1'b1; baud_tick = 1'b0;
        cyc(2000);
        chk("R5 rx awake without ticks", rx_clk_en, 1'b1);
        baud_tick = 1'b1;
        cyc(790);
        chk("R5 rx awake before window", rx_clk_en, 1'b1);
        cyc(20);
        chk("R5 rx asleep after window", rx_clk_en, 1'b0);

        // R4: host write wakes the transmitter and holds it awake
        thr_wr = 1'b1;
        cyc(1);
        chk("R4 tx wakes on write", tx_clk_en, 1'b1);
        thr_wr = 1'b0;
        cyc(5);
        chk("R4 tx held by pending write", tx_clk_en, 1'b1);
        tx_empty = 1'b0;
        cyc(5);
        chk("R4 tx awake while busy", tx_clk_en, 1'b1);
        tx_empty = 1'b1;
        cyc(2);
        chk("R3 tx sleeps after drain", tx_clk_en, 1'b0);

        // R9: idle flag
        chk("R9 idle when drained and quiet", port_idle, 1'b1);
        rx_in = 1'b0;
        cyc(50);
        chk("R9 not idle soon after edge", port_idle, 1'b0);
        cyc(200);
        chk("R9 idle after a quiet character", port_idle, 1'b1);
        thr_wr = 1'b1;
        cyc(1);
        chk("R9 not idle on write", port_idle, 1'b0);
        thr_wr = 1'b0;
        cyc(5);
        chk("R9 not idle with pending write", port_idle, 1'b0);
        tx_empty = 1'b0;
        cyc(1);
        tx_empty = 1'b1;
        cyc(2);
        chk("R9 idle after transmit drained", port_idle, 1'b1);

        // R7 / R8: direct powerdown
        cfg_direct_pd = 1'b1;
        cyc(1);
        chk("R7 tx_fifo_rst pulse", tx_fifo_rst, 1'b1);
        chk("R7 rx_fifo_rst pulse", rx_fifo_rst, 1'b1);
        chk("R8 tx gated", tx_clk_en, 1'b0);
        chk("R8 rx gated", rx_clk_en, 1'b0);
        cyc(1);
        chk("R7 pulse one clock", tx_fifo_rst | rx_fifo_rst, 1'b0);
        thr_wr = 1'b1;
        cyc(1);
        thr_wr = 1'b0;
        chk("R8 write does not wake tx", tx_clk_en, 1'b0);
        rx_in = 1'b1;
        cyc(5);
        chk("R8 edge does not wake rx", rx_clk_en, 1'b0);
        cfg_auto_en = 1'b0;
        cyc(1);
        cfg_direct_pd = 1'b0;
        cyc(1);
        chk("R8 tx resumes", tx_clk_en, 1'b1);
        chk("R8 rx resumes", rx_clk_en, 1'b1);
        chk("R8 no pulse on exit", tx_fifo_rst | rx_fifo_rst, 1'b0);

        // R11: module reset ends direct powerdown
        cfg_direct_pd = 1'b1;
        cyc(2);
        chk("R11 tx gated before reset", tx_clk_en, 1'b0);
        rst_n = 1'b0;
        cyc(1);
        chk("R11 tx running in reset", tx_clk_en, 1'b1);
        chk("R11 rx running in reset", rx_clk_en, 1'b1);
        cfg_direct_pd = 1'b0; rst_n = 1'b1;
        cyc(3);

        // Constrained random phase against the model
        cfg_auto_en = 1'b1;
        for (int i = 0; i < 30000; i++) begin
            cyc(1);
            thr_wr = ($urandom_range(49) == 0);
            baud_tick = ($urandom_range(1) == 0);
            if ($urandom_range(19) == 0)   tx_empty = ~tx_empty;
            if ($urandom_range(1499) == 0) rx_in = ~rx_in;
            if ($urandom_range(2999) == 0) cfg_auto_en = ~cfg_auto_en;
            if ($urandom_range(3999) == 0) cfg_direct_pd = ~cfg_direct_pd;
            if (!rst_n) rst_n = 1'b1;
            else if ($urandom_range(9999) == 0) rst_n = 1'b0;
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : watchdog
        #(4 * 190000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule